// File: doc/BRIEF.md
# Byte-Oriented I2C Master with Register Control

This block is a single-master I2C protocol engine driven through six 8-bit registers on a simple synchronous write/read port. Software drives the bus by writing whole control-word values. One value raises a START. Writing the data register sends one byte. Other values receive one byte with ACK or NACK, or ask for a STOP. After each step software polls or takes an interrupt on the status flags. The SCL low and high periods are counts of the peripheral clock. Each count can take an optional ninth bit from the interrupt-enable register.

The bus pins are open-drain. The block outputs one pull-low enable per line and samples SDA through one input. Word index n selects byte offset 4·n. The index order is data (0), control (1), status (2), interrupt enable (3), SCL-low count (4) and SCL-high count (5). Other indices read zero.

Top module: `i2c_master_regs`

## Requirements
- R1: After reset every register reads 0x00, both pull-low enables are off and the interrupt output is low.
- R2: Every bit occupies exactly L clocks with SCL pulled low and then H clocks with SCL released. L is the low count and H the high count. The SDA enable changes only during the low part.
- R3: A control write of 0x94 (bit7 enable, bit4 request-to-send, bit2 start) while the bus is free pulls SDA low with SCL released for H clocks. SCL is then held low. Status bit0 (transfer end) and bit4 (busy) then read 1.
- R4: A data write while the bus is held sends the byte MSB first and releases SDA for a ninth acknowledge bit. If SDA reads low on that bit, status bit0 sets.
- R5: If SDA reads high on the ninth bit of a transmitted byte, status bit2 (no-acknowledge) sets, bit0 stays clear and SCL stays held low.
- R6: The interrupt output is the OR over status bits 0, 2 and 4, each ANDed with the same bit of the interrupt-enable register.
- R7: Status bits 0 and 2 are sticky. A status write keeps each of them only where the written bit is 1, so writing 0x00 clears both. Bit4 is not writable.
- R8: A control write of 0x90 (enable, request-to-send, start clear, receive clear) while the bus is in use gives a STOP. If a byte is under way, the STOP follows that byte. The STOP is L clocks of SCL low with SDA low, H clocks of SCL high with SDA low, then H clocks of SDA released. After it, status bit4 reads 0.
- R9: A control write with bit7 and bit0 set (0x81) while the bus is held receives one byte into the data register and drives ACK low on the ninth bit. With bit6 also set (0xC1) SDA is released on the ninth bit (NACK). Status bit0 sets at the end of the byte.
- R10: A control write with bit7 clear releases both lines at the next clock, whatever the engine is doing, and status bit4 then reads 0.
- R11: Interrupt-enable bit7 supplies bit8 of the SCL-low count and bit6 supplies bit8 of the SCL-high count.
- R12: A data write while the bus is free only stores the byte and causes no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regIdx | input | 3 | Register word index (byte offset / 4) |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data for regIdx (combinational) |
| sdaIn | input | 1 | Sampled SDA line level |
| sclDriveLow | output | 1 | Pull SCL low when 1 |
| sdaDriveLow | output | 1 | Pull SDA low when 1 |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a command that lands while a byte is being shifted. Examples are a STOP request or a disable that arrives in the middle of a bit rather than in the held state. The stimulus issues such writes one clock after launching a byte, or a few clocks into it. A behavioural model in the bench keeps a queue of the expected SCL/SDA enables for every clock and compares it each cycle. A bench-side slave model shifts out the receive data and chooses ACK or NACK, so both acknowledge outcomes are produced on demand.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  // register word indices
  localparam int REG_DATA   = 0;
  localparam int REG_CTRL   = 1;
  localparam int REG_STATUS = 2;
  localparam int REG_IEN    = 3;
  localparam int REG_LOW    = 4;
  localparam int REG_HIGH   = 5;

  // control word bit positions
  localparam int C_EN   = 7;
  localparam int C_RACK = 6;
  localparam int C_RTS  = 4;
  localparam int C_STA  = 2;
  localparam int C_RX   = 0;

  // status / enable bit positions
  localparam int S_BUSY = 4;
  localparam int S_NACK = 2;
  localparam int S_DTE  = 0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_HOLD, ST_BIT_L, ST_BIT_H, ST_STOP_L, ST_STOP_H1, ST_STOP_H2
  } engState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadLow;
    logic loadHigh;
    logic loadTx;
    logic loadRx;
    logic shift;
  } dpCmd_t;

endpackage

// File: rtl/i2cm_datapath.sv
module i2cm_datapath
  import i2cm_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  input  logic [CNT_W-1:0] lowCnt,
  input  logic [CNT_W-1:0] highCnt,
  input  logic [7:0]       txByte,
  input  logic             rackBit,
  input  logic             sdaIn,
  output logic             timerDone,
  output logic             lastBit,
  output logic             sdaBit,
  output logic [7:0]       rxByte
);
  localparam int BITS  = 9;
  localparam int BCW   = $clog2(BITS);

  logic [CNT_W-1:0] timer;
  logic [BITS-1:0]  shReg;
  logic [BCW-1:0]   bitCnt;

  function automatic logic [CNT_W-1:0] firstVal(input logic [CNT_W-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) timer <= '0;
    else if (cmd.loadLow) timer <= firstVal(lowCnt);
    else if (cmd.loadHigh) timer <= firstVal(highCnt);
    else if (timer != '0) timer <= timer - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '1;
      bitCnt <= '0;
    end else if (cmd.loadTx) begin
      shReg  <= {txByte, 1'b1};
      bitCnt <= '0;
    end else if (cmd.loadRx) begin
      shReg  <= {8'hFF, rackBit};
      bitCnt <= '0;
    end else if (cmd.shift) begin
      shReg  <= {shReg[BITS-2:0], sdaIn};
      bitCnt <= bitCnt + 1'b1;
    end
  end

  assign timerDone = (timer == '0);
  assign lastBit   = (bitCnt == BCW'(BITS - 1));
  assign sdaBit    = shReg[BITS-1];
  assign rxByte    = shReg[7:0];

  // a load never coincides with a shift of the previous byte
  assert_one_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.shift && (cmd.loadTx || cmd.loadRx)));

endmodule

// File: rtl/i2cm_control.sv
module i2cm_control
  import i2cm_pkg::*;
#(
  parameter int IDX_W      = 3,
  parameter int CNT_W      = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [IDX_W-1:0] regIdx,
  input  logic [7:0]       regWdata,
  output logic [7:0]       regRdata,
  input  logic             sdaIn,
  input  logic             timerDone,
  input  logic             lastBit,
  input  logic             sdaBit,
  input  logic [7:0]       rxByte,
  output dpCmd_t           cmd,
  output logic [CNT_W-1:0] lowCnt,
  output logic [CNT_W-1:0] highCnt,
  output logic             sclDriveLow,
  output logic             sdaDriveLow,
  output logic             irq
);
  engState_t state, nextState;
  logic [7:0] dataReg, ctrlReg, ienReg, lowReg, highReg;
  logic dteFlag, nackFlag, stopPend, rxMode, busy;
  logic setDte, setNack, capture, enterStop, launchTx, launchRx;

  wire ctrlWe   = regWe && regIdx == IDX_W'(REG_CTRL);
  wire dataWe   = regWe && regIdx == IDX_W'(REG_DATA);
  wire statusWe = regWe && regIdx == IDX_W'(REG_STATUS);
  wire offWrite   = ctrlWe && !regWdata[C_EN];
  wire startWrite = ctrlWe && regWdata[C_EN] && regWdata[C_RTS] && regWdata[C_STA] && !regWdata[C_RX];
  wire stopWrite  = ctrlWe && regWdata[C_EN] && regWdata[C_RTS] && !regWdata[C_STA] && !regWdata[C_RX];
  wire rxWrite    = ctrlWe && regWdata[C_EN] && regWdata[C_RX];

  // count width: optional ninth bit from the enable register
  generate
    if (CNT_W > 8) begin : g_wide
      assign lowCnt  = CNT_W'({ienReg[7], lowReg});
      assign highCnt = CNT_W'({ienReg[6], highReg});
    end else begin : g_narrow
      assign lowCnt  = lowReg[CNT_W-1:0];
      assign highCnt = highReg[CNT_W-1:0];
    end
  endgenerate

  always_comb begin
    nextState = state;
    cmd = '0;
    {setDte, setNack, capture, enterStop, launchTx, launchRx} = '0;
    unique case (state)
      ST_IDLE: if (startWrite) begin nextState = ST_START; cmd.loadHigh = 1'b1; end
      ST_START: if (timerDone) begin nextState = ST_HOLD; setDte = 1'b1; end
      ST_HOLD: begin
        if (stopWrite || stopPend) begin
          nextState = ST_STOP_L; cmd.loadLow = 1'b1; enterStop = 1'b1;
        end else if (dataWe) begin
          nextState = ST_BIT_L; cmd.loadLow = 1'b1; cmd.loadTx = 1'b1; launchTx = 1'b1;
        end else if (rxWrite) begin
          nextState = ST_BIT_L; cmd.loadLow = 1'b1; cmd.loadRx = 1'b1; launchRx = 1'b1;
        end
      end
      ST_BIT_L: if (timerDone) begin nextState = ST_BIT_H; cmd.loadHigh = 1'b1; end
      ST_BIT_H: if (timerDone) begin
        if (lastBit) begin
          if (rxMode) begin capture = 1'b1; setDte = 1'b1; end
          else if (sdaIn) setNack = 1'b1;
          else setDte = 1'b1;
          if (stopPend || stopWrite) begin
            nextState = ST_STOP_L; cmd.loadLow = 1'b1; enterStop = 1'b1;
          end else nextState = ST_HOLD;
        end else begin
          nextState = ST_BIT_L; cmd.loadLow = 1'b1; cmd.shift = 1'b1;
        end
      end
      ST_STOP_L:  if (timerDone) begin nextState = ST_STOP_H1; cmd.loadHigh = 1'b1; end
      ST_STOP_H1: if (timerDone) begin nextState = ST_STOP_H2; cmd.loadHigh = 1'b1; end
      ST_STOP_H2: if (timerDone) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
    if (offWrite) begin
      nextState = ST_IDLE;
      cmd = '0;
      {setDte, setNack, capture, enterStop, launchTx, launchRx} = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      {dataReg, ctrlReg, ienReg, lowReg, highReg} <= '0;
      {dteFlag, nackFlag, stopPend, rxMode} <= '0;
    end else begin
      state <= nextState;
      if (ctrlWe) ctrlReg <= regWdata;
      if (regWe && regIdx == IDX_W'(REG_IEN))  ienReg  <= regWdata;
      if (regWe && regIdx == IDX_W'(REG_LOW))  lowReg  <= regWdata;
      if (regWe && regIdx == IDX_W'(REG_HIGH)) highReg <= regWdata;
      if (dataWe) dataReg <= regWdata;
      else if (capture) dataReg <= rxByte;
      dteFlag  <= (statusWe ? dteFlag  & regWdata[S_DTE]  : dteFlag)  | setDte;
      nackFlag <= (statusWe ? nackFlag & regWdata[S_NACK] : nackFlag) | setNack;
      if (offWrite || enterStop) stopPend <= 1'b0;
      else if (stopWrite && state != ST_IDLE) stopPend <= 1'b1;
      if (launchTx) rxMode <= 1'b0;
      else if (launchRx) rxMode <= 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);

  always_comb begin
    unique case (regIdx)
      IDX_W'(REG_DATA):   regRdata = dataReg;
      IDX_W'(REG_CTRL):   regRdata = ctrlReg;
      IDX_W'(REG_STATUS): regRdata = {3'b000, busy, 1'b0, nackFlag, 1'b0, dteFlag};
      IDX_W'(REG_IEN):    regRdata = ienReg;
      IDX_W'(REG_LOW):    regRdata = lowReg;
      IDX_W'(REG_HIGH):   regRdata = highReg;
      default:            regRdata = 8'h00;
    endcase
  end

  always_comb begin
    sclDriveLow = (state == ST_HOLD) || (state == ST_BIT_L) || (state == ST_STOP_L);
    unique case (state)
      ST_START, ST_STOP_L, ST_STOP_H1: sdaDriveLow = 1'b1;
      ST_BIT_L, ST_BIT_H:              sdaDriveLow = !sdaBit;
      default:                         sdaDriveLow = 1'b0;
    endcase
  end

  assign irq = (dteFlag && ienReg[S_DTE]) || (nackFlag && ienReg[S_NACK]) ||
               (busy && ienReg[S_BUSY]);

  // SDA is steady while SCL is released inside a data bit
  assert_sda_steady_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BIT_H && $past(state) == ST_BIT_H) |-> $stable(sdaDriveLow));
  assert_dte_after_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && timerDone && !offWrite) |=> dteFlag);
  assert_free_after_stop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOP_H2 && timerDone && !startWrite) |=> !busy);
  assert_release_on_off_R10: assert property (@(posedge clk) disable iff (!rstN)
    offWrite |=> (!sclDriveLow && !sdaDriveLow));
  assert_irq_has_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (dteFlag || nackFlag || busy));

endmodule

// File: rtl/i2c_master_regs.sv
module i2c_master_regs
  import i2cm_pkg::*;
#(
  parameter int IDX_W      = 3,
  parameter bit WIDE_COUNT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [IDX_W-1:0] regIdx,
  input  logic [7:0]       regWdata,
  output logic [7:0]       regRdata,
  input  logic             sdaIn,
  output logic             sclDriveLow,
  output logic             sdaDriveLow,
  output logic             irq
);
  localparam int CNT_W = WIDE_COUNT ? 9 : 8;

  dpCmd_t           cmd;
  logic [CNT_W-1:0] lowCnt, highCnt;
  logic             timerDone, lastBit, sdaBit;
  logic [7:0]       rxByte;

  i2cm_control #(.IDX_W(IDX_W), .CNT_W(CNT_W)) i_control (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regIdx(regIdx), .regWdata(regWdata),
    .regRdata(regRdata), .sdaIn(sdaIn), .timerDone(timerDone), .lastBit(lastBit),
    .sdaBit(sdaBit), .rxByte(rxByte), .cmd(cmd), .lowCnt(lowCnt), .highCnt(highCnt),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow), .irq(irq)
  );

  i2cm_datapath #(.CNT_W(CNT_W)) i_datapath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .lowCnt(lowCnt), .highCnt(highCnt),
    .txByte(regWdata), .rackBit(regWdata[C_RACK]), .sdaIn(sdaIn),
    .timerDone(timerDone), .lastBit(lastBit), .sdaBit(sdaBit), .rxByte(rxByte)
  );

endmodule

// File: tb/test_i2c_master_regs.sv
module test_i2c_master_regs;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [2:0] regIdx = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic sdaIn, sclDriveLow, sdaDriveLow, irq;

  int errors = 0;
  int checks = 0;
  int lowN = 3;
  int highN = 2;
  bit checking = 1'b0;
  bit finished = 1'b0;
  logic [1:0] expQ[$];           // {sclLow, sdaLow} per clock
  logic [1:0] holdExp = 2'b00;   // level once queue drains
  logic [8:0] slvPat = 9'h1FF;
  int slvIdx = 99;
  logic slvBit;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_master_regs i_i2c_master_regs (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regIdx(regIdx), .regWdata(regWdata),
    .regRdata(regRdata), .sdaIn(sdaIn), .sclDriveLow(sclDriveLow),
    .sdaDriveLow(sdaDriveLow), .irq(irq)
  );

  // slave model: one bit of its pattern per SCL low period
  always @(posedge sclDriveLow) slvIdx = slvIdx + 1;
  assign slvBit = (slvIdx >= 0 && slvIdx <= 8) ? slvPat[8 - slvIdx] : 1'b1;
  assign sdaIn  = !sdaDriveLow && slvBit;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // per-clock waveform comparison (R2)
  always @(negedge clk) begin
    if (checking) begin
      logic [1:0] e;
      e = (expQ.size() != 0) ? expQ.pop_front() : holdExp;
      chk("R2 line enables", int'({sclDriveLow, sdaDriveLow}), int'(e));
    end
  end

  task automatic pushN(input int n, input logic [1:0] v);
    for (int i = 0; i < n; i++) expQ.push_back(v);
  endtask

  task automatic pushByte(input logic [8:0] m);
    for (int i = 8; i >= 0; i--) begin
      pushN(lowN, {1'b1, !m[i]});
      pushN(highN, {1'b0, !m[i]});
    end
    holdExp = 2'b10;
  endtask

  task automatic pushStop();
    pushN(lowN, 2'b11);
    pushN(highN, 2'b01);
    pushN(highN, 2'b00);
    holdExp = 2'b00;
  endtask

  task automatic pushStart();
    pushN(highN, 2'b01);
    holdExp = 2'b10;
  endtask

  task automatic regWrite(input int idx, input logic [7:0] d);
    @(negedge clk); #1;
    regWe = 1'b1; regIdx = 3'(idx); regWdata = d;
    @(posedge clk); #1;
    regWe = 1'b0;
  endtask

  task automatic regRead(input int idx, output logic [7:0] d);
    @(negedge clk); #1;
    regIdx = 3'(idx);
    #1 d = regRdata;
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(posedge clk);
    @(negedge clk); #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checking = 1'b1;
    // R1: reset state
    for (int r = 0; r < 6; r++) begin
      regRead(r, rd);
      chk("R1 register reset", int'(rd), 0);
    end
    chk("R1 irq reset", int'(irq), 0);

    regWrite(4, 8'(lowN));
    regWrite(5, 8'(highN));
    regWrite(1, 8'h80);
    // R12: data write on a free bus causes nothing
    regWrite(0, 8'h55);
    repeat (4) @(negedge clk);
    regRead(0, rd);
    chk("R12 data stored", int'(rd), 8'h55);
    regRead(2, rd);
    chk("R12 no activity", int'(rd), 0);

    // R3: START
    regWrite(1, 8'h94); pushStart(); drain();
    regRead(2, rd);
    chk("R3 status after start", int'(rd), 8'h11);
    // R7: clear flags, busy remains
    regWrite(2, 8'h00);
    regRead(2, rd);
    chk("R7 status cleared", int'(rd), 8'h10);

    // R4: transmit with ACK
    slvPat = {8'hFF, 1'b0}; slvIdx = 0;
    regWrite(0, 8'hA5); pushByte({8'hA5, 1'b1}); drain();
    regRead(2, rd);
    chk("R4 ack gives transfer end", int'(rd), 8'h11);
    regWrite(2, 8'h00);

    // R5: transmit with NACK
    slvPat = {8'hFF, 1'b1}; slvIdx = 0;
    regWrite(0, 8'h3C); pushByte({8'h3C, 1'b1}); drain();
    regRead(2, rd);
    chk("R5 nack flag", int'(rd), 8'h14);
    // R6: interrupt gating
    regWrite(3, 8'h04);
    #1 chk("R6 irq nack enabled", int'(irq), 1);
    regWrite(3, 8'h01);
    #1 chk("R6 irq dte enabled only", int'(irq), 0);
    regWrite(3, 8'h00);

    // R8: STOP from held bus
    regWrite(1, 8'h90); pushStop(); drain();
    regRead(2, rd);
    chk("R8 busy clear, nack sticky", int'(rd), 8'h04);
    regWrite(2, 8'h00);

    // R9: receive with ACK
    regWrite(1, 8'h94); pushStart(); drain();
    regWrite(2, 8'h00);
    slvPat = {8'h6B, 1'b1}; slvIdx = 0;
    regWrite(1, 8'h81); pushByte({8'hFF, 1'b0}); drain();
    regRead(0, rd);
    chk("R9 received byte", int'(rd), 8'h6B);
    regRead(2, rd);
    chk("R9 transfer end", int'(rd), 8'h11);
    regWrite(2, 8'h00);

    // R9 + R8: receive with NACK, STOP requested mid-byte
    slvPat = {8'hC4, 1'b1}; slvIdx = 0;
    regWrite(1, 8'hC1); pushByte({8'hFF, 1'b1}); pushStop();
    regWrite(1, 8'h90);
    drain();
    regRead(0, rd);
    chk("R9 received byte nack", int'(rd), 8'hC4);
    regRead(2, rd);
    chk("R8 stop after byte", int'(rd), 8'h01);
    regWrite(2, 8'h00);

    // R10: disable mid-byte
    regWrite(1, 8'h94); pushStart(); drain();
    slvPat = {8'hFF, 1'b0}; slvIdx = 0;
    regWrite(0, 8'h81); pushByte({8'h81, 1'b1});
    repeat (5) @(negedge clk);
    #1 regWe = 1'b1; regIdx = 3'd1; regWdata = 8'h00;
    @(posedge clk); #1;
    regWe = 1'b0; expQ.delete(); holdExp = 2'b00;
    repeat (3) @(negedge clk);
    regRead(2, rd);
    chk("R10 busy clear after disable", int'(rd & 8'h10), 0);
    regWrite(2, 8'h00);

    // R11: ninth count bits
    regWrite(3, 8'hC0);
    lowN = 256 + 3; highN = 256 + 2;
    regWrite(1, 8'h94); pushStart(); drain();
    regRead(2, rd);
    chk("R11 start with long high", int'(rd), 8'h11);
    regWrite(1, 8'h90); pushStop(); drain();
    regRead(2, rd);
    chk("R11 stop with long counts", int'(rd), 8'h01);
    chk("R6 irq off with no enables", int'(irq), 0);

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule